// File: doc/BRIEF.md
# PCIe Completion Timeout Tracker

This block follows every Non-Posted request that the user logic issues and pairs it with the Completion that returns on the same tag. Each of the tag values has one tracking entry, which holds a valid bit, an age and the request descriptor. A free-running prescaler produces an age tick. On every tick, each live entry ages by one. When an entry's age reaches the programmed timeout period before its Completion arrives, the entry is retired. Its full descriptor (function, virtual function, VF-active bit, traffic class, attributes, byte length, tag) is pushed into a timeout record queue.

The record queue drains through a valid/ready stream. `rec_valid` is the user-facing timeout flag. It stays high as long as at least one record waits, and the record fields always show the head of the queue. A record leaves the queue on a clock edge where `rec_valid` and `rec_ready` are both high. While `rec_valid` is high the head is held steady, however long `rec_ready` stays low. When the queue is full, expired entries stay live and are retired later, so the back-pressure reaches the table and no record is lost. Two single-cycle error pulses report a duplicate request and a Completion that matches no live request.

Top module: `cpl_timeout_tracker`

## Requirements
- R1: After reset, `rec_valid`, `req_dup_err` and `cpl_unexpected` are low, and no tag holds a live entry.
- R2: A request with no Completion produces exactly one record. The record carries the request's function, virtual function, VF-active, traffic class, attributes, length and tag. `rec_valid` rises once the entry has seen `timeout_period` ticks and stays low until then.
- R3: A `cpl_valid` strobe whose tag matches a live entry clears that entry, and no record is produced for it. A request on that tag in the same cycle is accepted.
- R4: A `cpl_valid` strobe on a tag with no live entry changes nothing and raises `cpl_unexpected` for the one following cycle.
- R5: A request on a tag that already has a live entry is rejected and raises `req_dup_err` for the one following cycle. The existing entry, including its descriptor and age, is left unchanged.
- R6: `rec_valid` is high whenever the queue holds a record and stays high until the queue drains. It does not fall while a record waits. The head fields stay stable while `rec_valid` is high and `rec_ready` is low.
- R7: `rec_valid && rec_ready` removes the head record. `rec_ready` while the queue is empty has no effect.
- R8: When several entries are expired in the same cycle, they are retired one per cycle in ascending tag order.
- R9: When the queue is full, expired entries remain live and are retired as space frees. No record is dropped, and the queue never overflows.
- R10: `timeout_period` is compared live. Lowering it makes every entry whose age has already reached the new value expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Non-Posted request issued this cycle |
| req_func | input | 3 | Request function number |
| req_vfunc | input | 11 | Request virtual function number |
| req_vf_active | input | 1 | Request comes from a virtual function |
| req_tc | input | 3 | Request traffic class |
| req_attr | input | 2 | Request attributes |
| req_len | input | 12 | Expected Completion length in bytes |
| req_tag | input | 10 | Request tag |
| cpl_valid | input | 1 | Completion received this cycle |
| cpl_tag | input | 10 | Tag of the received Completion |
| timeout_period | input | AGE_W | Timeout window in prescaler ticks |
| req_dup_err | output | 1 | One-cycle pulse: request on a live tag was rejected |
| cpl_unexpected | output | 1 | One-cycle pulse: Completion matched no live tag |
| rec_valid | output | 1 | Timeout flag; head record is valid |
| rec_ready | input | 1 | Pop the head record |
| rec_func | output | 3 | Head record function number |
| rec_vfunc | output | 11 | Head record virtual function number |
| rec_vf_active | output | 1 | Head record VF-active bit |
| rec_tc | output | 3 | Head record traffic class |
| rec_attr | output | 2 | Head record attributes |
| rec_len | output | 12 | Head record byte length |
| rec_tag | output | 10 | Head record tag |

## Verification
If the valid bit of a table entry is wrong, the problem first shows as a missing or extra record about one timeout window later, or at once as a wrong error pulse on the next request or Completion for that tag. A wrong priority select or a queue that overflows shows up as records leaving in the wrong order or records that go missing. Both are visible on the first drain after several entries expire together. A queue count that underflows on an empty pop leaves `rec_valid` stuck high, so the next empty-queue check catches it.

// File: rtl/cto_pkg.sv
package cto_pkg;
  localparam int FUNC_W  = 3;
  localparam int VFUNC_W = 11;
  localparam int TC_W    = 3;
  localparam int ATTR_W  = 2;
  localparam int LEN_W   = 12;
  localparam int TAG_W   = 10;

  typedef struct packed {
    logic [FUNC_W-1:0]  func;
    logic [VFUNC_W-1:0] vfunc;
    logic               vf_act;
    logic [TC_W-1:0]    tc;
    logic [ATTR_W-1:0]  attr;
    logic [LEN_W-1:0]   len;
    logic [TAG_W-1:0]   tag;
  } cto_rec_t;
endpackage

// File: rtl/cto_prescaler.sv
module cto_prescaler #(
  parameter int TICK_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/cto_table.sv
module cto_table
  import cto_pkg::*;
#(
  parameter int AGE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req_valid,
  input  cto_rec_t         req_desc,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  input  logic [AGE_W-1:0] period,
  input  logic             q_full,
  output logic             push,
  output cto_rec_t         push_rec,
  output logic             dup_err,
  output logic             cpl_unexp
);
  localparam int NUM_TAGS = 1 << TAG_W;

  logic [NUM_TAGS-1:0] valid_q;
  logic [AGE_W-1:0]    age_q  [NUM_TAGS];
  cto_rec_t            desc_q [NUM_TAGS];

  logic             found;
  logic [TAG_W-1:0] sel;
  logic             cpl_hit;
  logic             req_busy;
  logic             req_take;

  // lowest expired tag wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (valid_q[i] && (age_q[i] >= period)) begin
        found = 1'b1;
        sel   = TAG_W'(i);
      end
    end
  end

  assign push     = found && !q_full;
  assign push_rec = desc_q[sel];
  assign cpl_hit  = cpl_valid && valid_q[cpl_tag];
  assign req_busy = valid_q[req_desc.tag] && !(cpl_hit && (cpl_tag == req_desc.tag));
  assign req_take = req_valid && !req_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      dup_err   <= 1'b0;
      cpl_unexp <= 1'b0;
    end else begin
      dup_err   <= req_valid && req_busy;
      cpl_unexp <= cpl_valid && !valid_q[cpl_tag];
      if (push)     valid_q[sel]          <= 1'b0;
      if (cpl_hit)  valid_q[cpl_tag]      <= 1'b0;
      if (req_take) valid_q[req_desc.tag] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (tick && valid_q[i] && (age_q[i] != '1)) age_q[i] <= age_q[i] + 1'b1;
    end
    if (req_take) begin
      age_q[req_desc.tag]  <= '0;
      desc_q[req_desc.tag] <= req_desc;
    end
  end

  p_retire_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !valid_q[$past(sel)]);
  p_cpl_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_hit && !(req_valid && req_desc.tag == cpl_tag)) |=> !valid_q[$past(cpl_tag)]);
  p_dup_keeps_desc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_busy && !push && !cpl_hit) |=> (valid_q[$past(req_desc.tag)] &&
      desc_q[$past(req_desc.tag)] == $past(desc_q[req_desc.tag])));
  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (found && q_full && !(cpl_hit && cpl_tag == sel)) |=> valid_q[$past(sel)]);
endmodule

// File: rtl/cto_fifo.sv
module cto_fifo
  import cto_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  cto_rec_t push_rec,
  output logic     full,
  output logic     out_valid,
  input  logic     out_ready,
  output cto_rec_t out_rec
);
  localparam int PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  cto_rec_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_rec   = mem[rd_q];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_rec;
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));
  p_empty_pop_noeffect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid && !push) |=> !out_valid);
  p_head_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));
endmodule

// File: rtl/cpl_timeout_tracker.sv
module cpl_timeout_tracker
  import cto_pkg::*;
#(
  parameter int AGE_W      = 16,
  parameter int TICK_DIV   = 64,
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [FUNC_W-1:0]  req_func,
  input  logic [VFUNC_W-1:0] req_vfunc,
  input  logic               req_vf_active,
  input  logic [TC_W-1:0]    req_tc,
  input  logic [ATTR_W-1:0]  req_attr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic               cpl_valid,
  input  logic [TAG_W-1:0]   cpl_tag,
  input  logic [AGE_W-1:0]   timeout_period,
  output logic               req_dup_err,
  output logic               cpl_unexpected,
  output logic               rec_valid,
  input  logic               rec_ready,
  output logic [FUNC_W-1:0]  rec_func,
  output logic [VFUNC_W-1:0] rec_vfunc,
  output logic               rec_vf_active,
  output logic [TC_W-1:0]    rec_tc,
  output logic [ATTR_W-1:0]  rec_attr,
  output logic [LEN_W-1:0]   rec_len,
  output logic [TAG_W-1:0]   rec_tag
);
  logic     tick, push, q_full;
  cto_rec_t req_desc, push_rec, head;

  assign req_desc = '{func: req_func, vfunc: req_vfunc, vf_act: req_vf_active,
                      tc: req_tc, attr: req_attr, len: req_len, tag: req_tag};

  cto_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  cto_table #(.AGE_W(AGE_W)) u_table (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_desc(req_desc),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .period(timeout_period), .q_full(q_full),
    .push(push), .push_rec(push_rec), .dup_err(req_dup_err), .cpl_unexp(cpl_unexpected));

  cto_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_rec(push_rec), .full(q_full),
    .out_valid(rec_valid), .out_ready(rec_ready), .out_rec(head));

  assign rec_func      = head.func;
  assign rec_vfunc     = head.vfunc;
  assign rec_vf_active = head.vf_act;
  assign rec_tc        = head.tc;
  assign rec_attr      = head.attr;
  assign rec_len       = head.len;
  assign rec_tag       = head.tag;

  p_unexp_from_cpl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_unexpected |-> $past(cpl_valid));
  p_dup_from_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_dup_err |-> $past(req_valid));
  p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> rec_valid);
endmodule

// File: tb/cpl_timeout_tracker_tb_top.sv
module cpl_timeout_tracker_tb_top;
  localparam int AGE_W = 8;
  localparam int DIV   = 4;
  localparam int DEPTH = 4;
  localparam int PER   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_vf_active = 0, cpl_valid = 0, rec_ready = 0;
  logic [2:0] req_func = 0, req_tc = 0;
  logic [10:0] req_vfunc = 0;
  logic [1:0] req_attr = 0;
  logic [11:0] req_len = 0;
  logic [9:0] req_tag = 0, cpl_tag = 0;
  logic [AGE_W-1:0] timeout_period = AGE_W'(PER);
  logic req_dup_err, cpl_unexpected, rec_valid, rec_vf_active;
  logic [2:0] rec_func, rec_tc;
  logic [10:0] rec_vfunc;
  logic [1:0] rec_attr;
  logic [11:0] rec_len;
  logic [9:0] rec_tag;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cpl_timeout_tracker #(.AGE_W(AGE_W), .TICK_DIV(DIV), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_func(req_func),
    .req_vfunc(req_vfunc), .req_vf_active(req_vf_active), .req_tc(req_tc),
    .req_attr(req_attr), .req_len(req_len), .req_tag(req_tag), .cpl_valid(cpl_valid),
    .cpl_tag(cpl_tag), .timeout_period(timeout_period), .req_dup_err(req_dup_err),
    .cpl_unexpected(cpl_unexpected), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_func(rec_func), .rec_vfunc(rec_vfunc), .rec_vf_active(rec_vf_active),
    .rec_tc(rec_tc), .rec_attr(rec_attr), .rec_len(rec_len), .rec_tag(rec_tag));

  // vector: tag, func, vfunc, vf_act, tc, attr, len, completed
  localparam int NV = 6;
  localparam logic [42:0] VEC [NV] = '{
    {10'd1,   3'd0, 11'd0,    1'b0, 3'd0, 2'd0, 12'd4,    1'b0},
    {10'd2,   3'd5, 11'd1234, 1'b1, 3'd6, 2'd2, 12'd512,  1'b1},
    {10'd1023,3'd7, 11'd2047, 1'b1, 3'd7, 2'd3, 12'd4095, 1'b0},
    {10'd0,   3'd2, 11'd17,   1'b0, 3'd1, 2'd1, 12'd128,  1'b1},
    {10'd300, 3'd3, 11'd600,  1'b1, 3'd4, 2'd2, 12'd64,   1'b0},
    {10'd512, 3'd1, 11'd5,    1'b0, 3'd2, 2'd1, 12'd256,  1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [42:0] v);
    {req_tag, req_func, req_vfunc, req_vf_active, req_tc, req_attr, req_len} = v[42:1];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic complete(input logic [9:0] t);
    cpl_tag = t; cpl_valid = 1'b1;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic pop();
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
  endtask

  function automatic logic [42:0] mk(input logic [9:0] t, input logic [11:0] l);
    return {t, 3'd1, 11'd9, 1'b0, 3'd2, 2'd1, l, 1'b0};
  endfunction

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    check(!rec_valid, "R1", "rec_valid after reset", rec_valid, 0);
    check(!req_dup_err && !cpl_unexpected, "R1", "pulses after reset",
          {req_dup_err, cpl_unexpected}, 0);

    // R2 R3: vector walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      if (VEC[i][0]) begin
        cyc(3);
        complete(VEC[i][42:33]);
        check(!cpl_unexpected, "R3", "matched cpl flagged", cpl_unexpected, 0);
        cyc(PER * DIV + 6);
        check(!rec_valid, "R3", "record after completion", rec_valid, 0);
      end else begin
        cyc((PER - 1) * DIV - 1);
        check(!rec_valid, "R2", "early timeout", rec_valid, 0);
        cyc(DIV + 6);
        check(rec_valid, "R2", "no timeout flag", rec_valid, 1);
        check({rec_tag, rec_func, rec_vfunc, rec_vf_active, rec_tc, rec_attr, rec_len}
              == VEC[i][42:1], "R2", "record fields",
              {rec_tag, rec_func, rec_vfunc, rec_vf_active, rec_tc, rec_attr, rec_len},
              VEC[i][42:1]);
        pop();
        check(!rec_valid, "R7", "flag after last pop", rec_valid, 0);
      end
    end

    // R4: completion on unused tag
    complete(10'd77);
    check(cpl_unexpected, "R4", "unexpected pulse", cpl_unexpected, 1);
    cyc(1);
    check(!cpl_unexpected, "R4", "pulse length", cpl_unexpected, 0);
    cyc(PER * DIV + 6);
    check(!rec_valid, "R4", "stray record", rec_valid, 0);

    // R5: duplicate request keeps original
    issue(mk(10'd40, 12'd100));
    check(!req_dup_err, "R5", "first issue flagged", req_dup_err, 0);
    issue(mk(10'd40, 12'd999));
    check(req_dup_err, "R5", "dup pulse", req_dup_err, 1);
    cyc(PER * DIV + 6);
    check(rec_valid && rec_tag == 10'd40, "R5", "record tag", rec_tag, 40);
    check(rec_len == 12'd100, "R5", "original length kept", rec_len, 100);
    pop();
    check(!rec_valid, "R5", "second record present", rec_valid, 0);

    // R7: pop while empty then one timeout
    pop();
    pop();
    issue(mk(10'd50, 12'd8));
    cyc(PER * DIV + 6);
    check(rec_valid && rec_tag == 10'd50, "R7", "record after empty pops", rec_tag, 50);
    pop();
    check(!rec_valid, "R7", "count corrupted by empty pop", rec_valid, 0);

    // R8 R10: simultaneous expiry in ascending order
    timeout_period = 8'd200;
    issue(mk(10'd9, 12'd1));
    issue(mk(10'd3, 12'd2));
    issue(mk(10'd7, 12'd3));
    cyc(3 * DIV);
    check(!rec_valid, "R10", "expiry before lowering", rec_valid, 0);
    timeout_period = 8'd1;
    cyc(8);
    check(rec_valid, "R10", "lowered period", rec_valid, 1);
    for (int k = 0; k < 3; k++) begin
      automatic int exp = (k == 0) ? 3 : (k == 1) ? 7 : 9;
      check(rec_tag == 10'(exp), "R8", "retire order", rec_tag, exp);
      pop();
    end
    check(!rec_valid, "R8", "extra records", rec_valid, 0);

    // R9 R6: more expiries than queue depth
    timeout_period = 8'd200;
    for (int k = 0; k < 6; k++) issue(mk(10'(20 + k), 12'(k)));
    cyc(3 * DIV);
    timeout_period = 8'd1;
    cyc(12);
    check(rec_valid, "R9", "flag with full queue", rec_valid, 1);
    cyc(5);
    check(rec_valid && rec_tag == 10'd20, "R6", "head held while not ready", rec_tag, 20);
    for (int k = 0; k < 6; k++) begin
      check(rec_valid, "R6", "flag fell before drain", rec_valid, 1);
      check(rec_tag == 10'(20 + k), "R9", "record lost or reordered", rec_tag, 20 + k);
      pop();
      cyc(1);
    end
    check(!rec_valid, "R9", "flag after drain", rec_valid, 0);

    // R3: same-cycle completion and reissue on the same tag
    timeout_period = 8'd200;
    issue(mk(10'd60, 12'd11));
    {req_tag, req_func, req_vfunc, req_vf_active, req_tc, req_attr, req_len} = mk(10'd60, 12'd22) >> 1;
    req_valid = 1'b1; cpl_tag = 10'd60; cpl_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
    check(!req_dup_err, "R3", "reissue with cpl rejected", req_dup_err, 0);
    cyc(3 * DIV);
    timeout_period = 8'd1;
    cyc(8);
    check(rec_valid && rec_len == 12'd22, "R3", "reissued descriptor", rec_len, 22);
    pop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule